// File: doc/BRIEF.md
# Hash Accelerator Register Front End

This block is the bus-facing control unit of a hash accelerator. A simple 32-bit register bus, with one write strobe and one read strobe, reaches five registers. Four are plain parameter registers: source address, digest destination address, key buffer address and data length. The fifth is a command register, and a status register sits beside them. Writing the command register asks for an operation. The block decodes the algorithm and output-format fields of the written word and checks that the request is legal. It then hands a one-cycle start pulse and a latched parameter set to a downstream engine.

The block tracks a live busy bit while the engine works. When the engine reports done, the block latches a sticky completion flag. A second sticky error flag records each command that was refused. Both flags are cleared by writing ones to their status bits. The engine side is a plain start/done handshake, with no back-pressure, because the block issues a start only when no operation is in flight.

Top module: `hash_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero, `rdata` is zero, and `eng_start` is low.
- R2: The source (0x20), digest (0x24), key (0x28), length (0x2C) and command (0x30) registers read back the last value written to them. Read data appears on `rdata` in the cycle after the clock edge that samples `rd_en`. Any other offset reads zero, and writes to it have no effect.
- R3: Command bits {10,6,5,4} select the algorithm, shown on `eng_alg` as 0=MD5 for 0000, 1=SHA-1 for 0010, 2=SHA-224 for 0100, 3=SHA-256 for 0101, 4=SHA-384 for 1110 and 5=SHA-512 for 0110. Any other pattern is refused.
- R4: On an accepted command, command bit 3 drives `eng_sha_be`, bit 2 drives `eng_md5_le` and bit 18 drives `eng_sg`.
- R5: An accepted command write raises `eng_start` for exactly one cycle, the cycle after the write edge. In that cycle, `eng_src`, `eng_dst`, `eng_key` and `eng_len` carry the register values that held at the write, and they stay stable until the next start.
- R6: Status bit 0 (busy) rises one cycle after the start pulse. Busy falls at the edge where `eng_done` is sampled high while busy, and status bit 9 (done) is set at that same edge.
- R7: The done flag stays set until a status write with bit 9 at one clears it. A status write with bit 9 at zero leaves it set.
- R8: A command write while busy is set, or while a start pulse is pending, issues no start and sets status bit 16 (error). Writing one to bit 16 clears the error flag. Writing zero to it has no effect.
- R9: A command whose source address has bit 31 clear, or whose digest address is not 8-byte aligned, issues no start and sets the error flag.
- R10: `eng_done` while the block is idle changes neither busy nor the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_alg | output | 3 | Decoded algorithm code |
| eng_sha_be | output | 1 | Big-endian SHA output select |
| eng_md5_le | output | 1 | Little-endian MD5 output select |
| eng_sg | output | 1 | Scatter-gather mode enable |
| eng_src | output | 32 | Latched source address |
| eng_dst | output | 32 | Latched digest address |
| eng_key | output | 32 | Latched key buffer address |
| eng_len | output | 32 | Latched data length |
| eng_done | input | 1 | Engine completion indication |

## Verification
The results arrive at fixed cycles. Read data is due one cycle after the read edge. The start pulse and the latched engine parameters are due in the cycle after the command write edge. Busy changes one edge later again, so a status read begun one cycle after the pulse shows busy set. The done and error flags change at the very edge that samples `eng_done` or the refused write. The bench drives every input on the falling edge and samples every output on the next falling edge after the edge where the result is due, so no check races a clock edge.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5,
    ALG_BAD    = 3'd7
  } hash_alg_e;

  localparam logic [7:0] OFF_STAT = 8'h1C;
  localparam logic [7:0] OFF_SRC  = 8'h20;
  localparam logic [7:0] OFF_DST  = 8'h24;
  localparam logic [7:0] OFF_KEY  = 8'h28;
  localparam logic [7:0] OFF_LEN  = 8'h2C;
  localparam logic [7:0] OFF_CMD  = 8'h30;

  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 9;
  localparam int ST_ERR    = 16;
  localparam int CMD_MD5LE = 2;
  localparam int CMD_SHABE = 3;
  localparam int CMD_SG    = 18;
  localparam int SRC_MEM   = 31;
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
  import hreg_pkg::*;
(
  input  logic [3:0] alg_bits,  // command bits {10,6,5,4}
  output hash_alg_e  alg
);
  always_comb begin
    unique case (alg_bits)
      4'b0000: alg = ALG_MD5;
      4'b0010: alg = ALG_SHA1;
      4'b0100: alg = ALG_SHA224;
      4'b0101: alg = ALG_SHA256;
      4'b1110: alg = ALG_SHA384;
      4'b0110: alg = ALG_SHA512;
      default: alg = ALG_BAD;
    endcase
  end
endmodule

// File: rtl/hreg_status.sv
module hreg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic eng_done,
  input  logic reject,
  input  logic clr_done,
  input  logic clr_err,
  output logic busy,
  output logic done_flag,
  output logic err_flag
);
  logic finish;
  assign finish = busy && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (launch)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;

      if (finish)        done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;

      if (reject)       err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hreg_readmux.sv
module hreg_readmux
  import hreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] stat_word,
  input  logic [DATA_W-1:0] src_q,
  input  logic [DATA_W-1:0] dst_q,
  input  logic [DATA_W-1:0] key_q,
  input  logic [DATA_W-1:0] len_q,
  input  logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] rd_word
);
  always_comb begin
    rd_word = '0;
    if      (addr == ADDR_W'(OFF_STAT)) rd_word = stat_word;
    else if (addr == ADDR_W'(OFF_SRC))  rd_word = src_q;
    else if (addr == ADDR_W'(OFF_DST))  rd_word = dst_q;
    else if (addr == ADDR_W'(OFF_KEY))  rd_word = key_q;
    else if (addr == ADDR_W'(OFF_LEN))  rd_word = len_q;
    else if (addr == ADDR_W'(OFF_CMD))  rd_word = cmd_q;
  end
endmodule

// File: rtl/hash_ctrl_regs.sv
module hash_ctrl_regs
  import hreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DST_ALIGN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              eng_start,
  output logic [2:0]        eng_alg,
  output logic              eng_sha_be,
  output logic              eng_md5_le,
  output logic              eng_sg,
  output logic [DATA_W-1:0] eng_src,
  output logic [DATA_W-1:0] eng_dst,
  output logic [DATA_W-1:0] eng_key,
  output logic [DATA_W-1:0] eng_len,
  input  logic              eng_done
);
  localparam int ALIGN_LSB = $clog2(DST_ALIGN);

  logic [DATA_W-1:0] src_q, dst_q, key_q, len_q, cmd_q;
  logic [DATA_W-1:0] stat_word, rd_word;
  logic              busy, done_flag, err_flag;
  hash_alg_e         alg_dec;

  logic cmd_wr, stat_wr, pending, legal, accept, reject;

  assign cmd_wr  = wr_en && (addr == ADDR_W'(OFF_CMD));
  assign stat_wr = wr_en && (addr == ADDR_W'(OFF_STAT));
  assign pending = busy || eng_start;
  assign legal   = src_q[SRC_MEM] && (dst_q[ALIGN_LSB-1:0] == '0) &&
                   (alg_dec != ALG_BAD);
  assign accept  = cmd_wr && !pending && legal;
  assign reject  = cmd_wr && !accept;

  hreg_decode u_decode (
    .alg_bits ({wdata[10], wdata[6], wdata[5], wdata[4]}),
    .alg      (alg_dec)
  );

  hreg_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (eng_start),
    .eng_done  (eng_done),
    .reject    (reject),
    .clr_done  (stat_wr && wdata[ST_DONE]),
    .clr_err   (stat_wr && wdata[ST_ERR]),
    .busy      (busy),
    .done_flag (done_flag),
    .err_flag  (err_flag)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ST_BUSY] = busy;
    stat_word[ST_DONE] = done_flag;
    stat_word[ST_ERR]  = err_flag;
  end

  hreg_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_readmux (
    .addr      (addr),
    .stat_word (stat_word),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .key_q     (key_q),
    .len_q     (len_q),
    .cmd_q     (cmd_q),
    .rd_word   (rd_word)
  );

  // parameter registers and read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      key_q <= '0;
      len_q <= '0;
      cmd_q <= '0;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(OFF_SRC)) src_q <= wdata;
        if (addr == ADDR_W'(OFF_DST)) dst_q <= wdata;
        if (addr == ADDR_W'(OFF_KEY)) key_q <= wdata;
        if (addr == ADDR_W'(OFF_LEN)) len_q <= wdata;
        if (addr == ADDR_W'(OFF_CMD)) cmd_q <= wdata;
      end
      if (rd_en) rdata <= rd_word;
    end
  end

  // engine launch: pulse plus parameter snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start  <= 1'b0;
      eng_alg    <= '0;
      eng_sha_be <= 1'b0;
      eng_md5_le <= 1'b0;
      eng_sg     <= 1'b0;
      eng_src    <= '0;
      eng_dst    <= '0;
      eng_key    <= '0;
      eng_len    <= '0;
    end else begin
      eng_start <= accept;
      if (accept) begin
        eng_alg    <= alg_dec;
        eng_sha_be <= wdata[CMD_SHABE];
        eng_md5_le <= wdata[CMD_MD5LE];
        eng_sg     <= wdata[CMD_SG];
        eng_src    <= src_q;
        eng_dst    <= dst_q;
        eng_key    <= key_q;
        eng_len    <= len_q;
      end
    end
  end
endmodule

// File: rtl/hreg_checker.sv
module hreg_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_start,
  input logic              eng_done,
  input logic              busy,
  input logic              done_flag,
  input logic              err_flag,
  input logic [2:0]        eng_alg,
  input logic [DATA_W-1:0] eng_src,
  input logic [DATA_W-1:0] eng_dst,
  input logic              cmd_wr,
  input logic              done_clr_req
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);  // R5
  AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> busy);  // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> (!busy && done_flag));  // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr_req) |=> done_flag);  // R7
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !eng_start);  // R8
  AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (err_flag && !eng_start));  // R8
  AST_START_LEGAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_src[31] && eng_dst[2:0] == 3'd0));  // R9
  AST_START_ALG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_alg <= 3'd5));  // R3
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eng_start && !done_flag) |=> !done_flag);  // R10
endmodule

bind hash_ctrl_regs hreg_checker #(.DATA_W(DATA_W)) u_hreg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_start    (eng_start),
  .eng_done     (eng_done),
  .busy         (busy),
  .done_flag    (done_flag),
  .err_flag     (err_flag),
  .eng_alg      (eng_alg),
  .eng_src      (eng_src),
  .eng_dst      (eng_dst),
  .cmd_wr       (cmd_wr),
  .done_clr_req (stat_wr && wdata[9])
);

// File: tb/hash_ctrl_regs_bench.sv
`timescale 1ns/1ps
module hash_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, eng_src, eng_dst, eng_key, eng_len;
  logic        eng_start, eng_sha_be, eng_md5_le, eng_sg;
  logic [2:0]  eng_alg;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hash_ctrl_regs u_hash_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eng_start(eng_start), .eng_alg(eng_alg),
    .eng_sha_be(eng_sha_be), .eng_md5_le(eng_md5_le), .eng_sg(eng_sg),
    .eng_src(eng_src), .eng_dst(eng_dst), .eng_key(eng_key), .eng_len(eng_len),
    .eng_done(eng_done)
  );

  localparam logic [7:0] A_STAT = 8'h1C, A_SRC = 8'h20, A_DST = 8'h24,
                         A_KEY = 8'h28, A_LEN = 8'h2C, A_CMD = 8'h30;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_alg(input logic [31:0] c);
    case ({c[10], c[6], c[5], c[4]})
      4'b0000: return 3'd0;
      4'b0010: return 3'd1;
      4'b0100: return 3'd2;
      4'b0101: return 3'd3;
      4'b1110: return 3'd4;
      4'b0110: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [31:0] pat_bits(input int k);
    logic [3:0] p;
    case (k)
      0: p = 4'b0000; 1: p = 4'b0010; 2: p = 4'b0100; 3: p = 4'b0101;
      4: p = 4'b1110; 5: p = 4'b0110; 6: p = 4'b0001; default: p = 4'b1000;
    endcase
    return {21'd0, p[3], 3'd0, p[2], p[1], p[0], 4'd0};
  endfunction

  function automatic logic [31:0] stat_exp(input bit b, input bit d, input bit e);
    return {15'd0, e, 6'd0, d, 8'd0, b};
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_op(input int dly);
    repeat (dly) @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic [7:0]  regs[6];
    void'($urandom(32'd4242));
    regs = '{A_STAT, A_SRC, A_DST, A_KEY, A_LEN, A_CMD};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(eng_start == 1'b0, "R1 start low", {31'd0, eng_start}, 0);
    chk(rdata == '0, "R1 rdata zero", rdata, 0);
    foreach (regs[i]) begin
      bus_rd(regs[i], r);
      chk(r == '0, "R1 reg zero", r, 0);
    end

    // R2 readback and unmapped offsets
    bus_wr(A_SRC, 32'h8000_1000);
    bus_wr(A_DST, 32'h0000_0040);
    bus_wr(A_KEY, 32'h0000_ABCD);
    bus_wr(A_LEN, 32'h0000_0100);
    bus_wr(A_STAT - 8'h1C, 32'hFFFF_FFFF);
    bus_wr(8'h34, 32'h1234_5678);
    bus_rd(A_SRC, r); chk(r == 32'h8000_1000, "R2 src", r, 32'h8000_1000);
    bus_rd(A_DST, r); chk(r == 32'h40, "R2 dst", r, 32'h40);
    bus_rd(A_KEY, r); chk(r == 32'hABCD, "R2 key", r, 32'hABCD);
    bus_rd(A_LEN, r); chk(r == 32'h100, "R2 len", r, 32'h100);
    bus_rd(8'h00, r); chk(r == '0, "R2 unmapped 0x00", r, 0);
    bus_rd(8'h34, r); chk(r == '0, "R2 unmapped 0x34", r, 0);
    bus_rd(A_STAT, r); chk(r == '0, "R2 status untouched", r, 0);

    // R10 done while idle
    finish_op(0);
    bus_rd(A_STAT, r); chk(r == '0, "R10 idle done ignored", r, 0);

    // R5/R6/R8/R7 directed sequence
    bus_wr(A_CMD, 32'h0000_0058);  // SHA-256, big-endian
    chk(eng_start == 1'b1, "R5 start pulse", {31'd0, eng_start}, 1);
    chk(eng_alg == 3'd3, "R3 sha256 code", {29'd0, eng_alg}, 3);
    chk(eng_sha_be == 1'b1, "R4 sha_be", {31'd0, eng_sha_be}, 1);
    @(negedge clk);
    chk(eng_start == 1'b0, "R5 pulse one cycle", {31'd0, eng_start}, 0);
    bus_rd(A_STAT, r); chk(r == stat_exp(1, 0, 0), "R6 busy set", r, stat_exp(1, 0, 0));
    bus_wr(A_CMD, 32'h0000_0020);
    chk(eng_start == 1'b0, "R8 busy cmd ignored", {31'd0, eng_start}, 0);
    chk(eng_alg == 3'd3, "R8 params kept", {29'd0, eng_alg}, 3);
    bus_rd(A_STAT, r); chk(r == stat_exp(1, 0, 1), "R8 error set", r, stat_exp(1, 0, 1));
    finish_op(2);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 1, 1), "R6 done sets flag", r, stat_exp(0, 1, 1));
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 1, 1), "R7 zero write no effect", r, stat_exp(0, 1, 1));
    bus_wr(A_STAT, 32'h0000_0200);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 0, 1), "R7 done cleared", r, stat_exp(0, 0, 1));
    bus_wr(A_STAT, 32'h0001_0000);
    bus_rd(A_STAT, r); chk(r == '0, "R8 error cleared", r, 0);

    // R8 back-to-back command during pending start
    @(negedge clk);
    wr_en = 1'b1; addr = A_CMD; wdata = 32'h20;
    @(negedge clk);
    wdata = 32'h40;
    @(negedge clk);
    wr_en = 1'b0;
    chk(eng_start == 1'b0, "R8 pending cmd no restart", {31'd0, eng_start}, 0);
    chk(eng_alg == 3'd1, "R8 first cmd kept", {29'd0, eng_alg}, 1);
    bus_rd(A_CMD, r); chk(r == 32'h40, "R2 cmd readback", r, 32'h40);
    finish_op(1);
    bus_wr(A_STAT, 32'h0001_0200);

    // R9 address legality, R3 bad pattern
    bus_wr(A_SRC, 32'h0000_1000);
    bus_wr(A_CMD, 32'h20);
    chk(eng_start == 1'b0, "R9 low src refused", {31'd0, eng_start}, 0);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 0, 1), "R9 error low src", r, stat_exp(0, 0, 1));
    bus_wr(A_STAT, 32'h0001_0000);
    bus_wr(A_SRC, 32'h8000_0000);
    bus_wr(A_DST, 32'h0000_0044);
    bus_wr(A_CMD, 32'h20);
    chk(eng_start == 1'b0, "R9 misaligned dst refused", {31'd0, eng_start}, 0);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 0, 1), "R9 error misaligned", r, stat_exp(0, 0, 1));
    bus_wr(A_STAT, 32'h0001_0000);
    bus_wr(A_DST, 32'h0000_0048);
    bus_wr(A_CMD, 32'h10);
    chk(eng_start == 1'b0, "R3 bad pattern refused", {31'd0, eng_start}, 0);
    bus_rd(A_STAT, r); chk(r == stat_exp(0, 0, 1), "R3 bad pattern error", r, stat_exp(0, 0, 1));
    bus_wr(A_STAT, 32'h0001_0000);

    // constrained random commands
    for (int it = 0; it < 60; it++) begin
      logic [31:0] src, dst, key, len, cmd;
      bit ok;
      src = $urandom;
      if ($urandom % 5 != 0) src[31] = 1'b1; else src[31] = 1'b0;
      dst = $urandom & 32'hFFFF_FFF8;
      if ($urandom % 5 == 0) dst[2:0] = 3'(1 + $urandom % 7);
      key = $urandom;
      len = $urandom;
      cmd = ($urandom & ~32'h0000_0470) | pat_bits(int'($urandom % 8));
      ok = src[31] && dst[2:0] == 3'd0 && exp_alg(cmd) != 3'd7;
      bus_wr(A_SRC, src);
      bus_wr(A_DST, dst);
      bus_wr(A_KEY, key);
      bus_wr(A_LEN, len);
      bus_wr(A_CMD, cmd);
      chk(eng_start == ok, "R5 random start", {31'd0, eng_start}, {31'd0, ok});
      if (ok) begin
        chk(eng_alg == exp_alg(cmd), "R3 random alg", {29'd0, eng_alg}, {29'd0, exp_alg(cmd)});
        chk({eng_sha_be, eng_md5_le, eng_sg} == {cmd[3], cmd[2], cmd[18]},
            "R4 random flags", {29'd0, eng_sha_be, eng_md5_le, eng_sg},
            {29'd0, cmd[3], cmd[2], cmd[18]});
        chk(eng_src == src && eng_dst == dst, "R5 random addrs", eng_src, src);
        chk(eng_key == key && eng_len == len, "R5 random key/len", eng_len, len);
        @(negedge clk);
        bus_rd(A_STAT, r); chk(r == stat_exp(1, 0, 0), "R6 random busy", r, stat_exp(1, 0, 0));
        finish_op(int'($urandom % 6));
        bus_rd(A_STAT, r); chk(r == stat_exp(0, 1, 0), "R6 random done", r, stat_exp(0, 1, 0));
      end else begin
        bus_rd(A_STAT, r); chk(r == stat_exp(0, 0, 1), "R9 random refusal", r, stat_exp(0, 0, 1));
      end
      bus_wr(A_STAT, 32'h0001_0200);
      bus_rd(A_STAT, r); chk(r == '0, "R7 random clear", r, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule